// File: doc/BRIEF.md
# Two-Port Synchronous RAM with Selectable Clock Assignment

This block is a synchronous memory with two ports. Port A writes. Port B reads. Port A takes a write address, write data and a write enable. Port B takes a read address, a read enable and an address-hold input, and it drives the read data. Both ports have the same data width. The array holds 2^ADDR_W words of DATA_W bits.

Two clocks, `clk_pri` and `clk_sec`, each with its own clock enable, drive the block's registers. A compile-time parameter, `MODE`, decides which of the two clocks drives each register. The write always runs on `clk_pri`. The port-B address register and the port-B output register can each be placed on either clock. This lets one design serve several systems:

- a system with a single clock,
- a system that writes in one domain and reads in another,
- a system that splits input timing from output timing,
- a system that runs each port in its own domain.

A single active-low reset input is synchronized separately into each clock domain. Reset is asserted at once and released on that domain's clock.

Top module: `dual_clock_ram`

## Requirements
- R1: A word is written to the address on `a_addr` at a rising edge of `clk_pri` when both `a_wen` and `ce_pri` are high at that edge. In every other case the array is left unchanged.
- R2: The registered port-B address is captured on one rising edge of its clock. `b_rdata` shows the word at that address after the next rising edge of the read-data clock. In the single-clock mode, both of these edges are edges of `clk_pri`.
- R3: While `b_ren` is low, `b_rdata` keeps its value. This holds even if the port-B address or the stored data changes.
- R4: While `b_addr_hold` is high, the registered port-B address keeps its previous value and `b_addr` is ignored. Reads continue to return the current contents at the held address.
- R5: While `ce_pri` is low, every register clocked by `clk_pri` holds, and this includes the write. While `ce_sec` is low, every register clocked by `clk_sec` holds.
- R6: `MODE` selects the clock for each register:
  - 0 (single clock): every register runs on `clk_pri`, and `clk_sec` is unused.
  - 1 (read/write split): the port-B address register and the read-data register both run on `clk_sec`.
  - 2 (input/output split): the port-B address register runs on `clk_pri`, and the read-data register runs on `clk_sec`.
  - 3 (independent ports): all port-B registers run on `clk_sec`.
- R7: While `rst_n` is low, `b_rdata` is 0 and the registered port-B address is 0. Each domain leaves reset synchronously to its own clock.
- R8: In the single-clock mode, a read and a write to the same address on the same edge return the old word. The new word appears after the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock. Drives the write in every mode. |
| clk_sec | input | 1 | Secondary clock. Drives the registers that `MODE` assigns to it. |
| ce_pri | input | 1 | Clock enable for every register on `clk_pri`. |
| ce_sec | input | 1 | Clock enable for every register on `clk_sec`. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| a_wdata | input | DATA_W | Write data for port A. |
| a_addr | input | ADDR_W | Write address for port A. |
| a_wen | input | 1 | Write enable for port A. |
| b_addr | input | ADDR_W | Read address for port B. |
| b_ren | input | 1 | Read enable. Lets the read-data register update. |
| b_addr_hold | input | 1 | Freezes the registered read address while high. |
| b_rdata | output | DATA_W | Registered read data for port B. |

## Verification
Assertions check the following on every cycle:

- a write with the enable high lands in the array;
- the registered address stays frozen under the hold input or a low clock enable;
- the read data stays stable when the read enable or its clock enable is low.

Other behaviour can only be shown by the bench's scenarios:

- the exact clock assignment of each mode, shown by stopping one clock while the other runs;
- the read latency;
- the old-data result on a same-edge collision;
- data integrity under mixed traffic.

The bench does these by running four instances, one per mode, side by side.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;

  typedef enum logic [1:0] {
    CLKM_SINGLE  = 2'd0,
    CLKM_RDWR    = 2'd1,
    CLKM_INOUT   = 2'd2,
    CLKM_PERPORT = 2'd3
  } clk_mode_e;

  // Port-B address register is on the secondary clock
  function automatic logic addr_uses_sec(clk_mode_e m);
    return (m == CLKM_RDWR) || (m == CLKM_PERPORT);
  endfunction

  // Read-data register is on the secondary clock
  function automatic logic rdata_uses_sec(clk_mode_e m);
    return (m != CLKM_SINGLE);
  endfunction

endpackage

// File: rtl/dcr_rst_sync.sv
`timescale 1ns/1ps
module dcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dcr_array.sv
`timescale 1ns/1ps
module dcr_array #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R1: an enabled write is present in the array after the edge
  assert_write_lands_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
    wen |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dcr_read_port.sv
`timescale 1ns/1ps
module dcr_read_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              aclk,
  input  logic              arst_n,
  input  logic              ace,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  input  logic              qclk,
  input  logic              qrst_n,
  input  logic              qce,
  input  logic              ren,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] q
);

  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] q_d;

  always_comb begin
    addr_d = addr_q;
    if (ace && !hold) addr_d = addr_in;
  end

  always_ff @(posedge aclk or negedge arst_n) begin
    if (!arst_n) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  always_comb begin
    q_d = q;
    if (qce && ren) q_d = rdata;
  end

  always_ff @(posedge qclk or negedge qrst_n) begin
    if (!qrst_n) q <= '0;
    else         q <= q_d;
  end

  assert_hold_freezes_addr_R4: assert property (@(posedge aclk) disable iff (!arst_n)
    hold |=> $stable(addr_q));

  assert_addr_ce_low_R5: assert property (@(posedge aclk) disable iff (!arst_n)
    !ace |=> $stable(addr_q));

  assert_rdata_hold_R3: assert property (@(posedge qclk) disable iff (!qrst_n)
    !ren |=> $stable(q));

  assert_rdata_ce_low_R5: assert property (@(posedge qclk) disable iff (!qrst_n)
    !qce |=> $stable(q));

endmodule

// File: rtl/dual_clock_ram.sv
`timescale 1ns/1ps
module dual_clock_ram
  import dcr_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter clk_mode_e   MODE        = CLKM_PERPORT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_pri,
  input  logic              clk_sec,
  input  logic              ce_pri,
  input  logic              ce_sec,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wen,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_ren,
  input  logic              b_addr_hold,
  output logic [DATA_W-1:0] b_rdata
);

  localparam logic ADDR_SEC = addr_uses_sec(MODE);
  localparam logic Q_SEC    = rdata_uses_sec(MODE);

  logic rst_pri_n, rst_sec_n;

  dcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_pri (
    .clk(clk_pri), .arst_n(rst_n), .srst_n(rst_pri_n));

  dcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sec (
    .clk(clk_sec), .arst_n(rst_n), .srst_n(rst_sec_n));

  logic addr_clk, addr_ce, addr_rst_n;
  logic q_clk, q_ce, q_rst_n;

  generate
    if (ADDR_SEC) begin : g_addr_sec
      assign addr_clk   = clk_sec;
      assign addr_ce    = ce_sec;
      assign addr_rst_n = rst_sec_n;
    end else begin : g_addr_pri
      assign addr_clk   = clk_pri;
      assign addr_ce    = ce_pri;
      assign addr_rst_n = rst_pri_n;
    end

    if (Q_SEC) begin : g_q_sec
      assign q_clk   = clk_sec;
      assign q_ce    = ce_sec;
      assign q_rst_n = rst_sec_n;
    end else begin : g_q_pri
      assign q_clk   = clk_pri;
      assign q_ce    = ce_pri;
      assign q_rst_n = rst_pri_n;
    end
  endgenerate

  logic              wen;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;

  assign wen = a_wen & ce_pri;

  dcr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .wclk(clk_pri), .wrst_n(rst_pri_n), .wen(wen), .waddr(a_addr),
    .wdata(a_wdata), .raddr(rd_addr), .rdata(rd_word));

  dcr_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .aclk(addr_clk), .arst_n(addr_rst_n), .ace(addr_ce), .hold(b_addr_hold),
    .addr_in(b_addr), .addr_q(rd_addr),
    .qclk(q_clk), .qrst_n(q_rst_n), .qce(q_ce), .ren(b_ren),
    .rdata(rd_word), .q(b_rdata));

endmodule

// File: tb/dual_clock_ram_tb.sv
`timescale 1ns/100ps
module dual_clock_ram_tb;
  import dcr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NMODE = 4;

  logic clk0, clk1, run0, run1;
  logic ce_pri, ce_sec, rst_n;
  logic [DW-1:0] a_wdata;
  logic [AW-1:0] a_addr, b_addr;
  logic a_wen, b_ren, b_hold;
  logic [DW-1:0] q_all [NMODE];
  logic [DW-1:0] model_mem [1<<AW];
  int n_checks = 0;
  int n_err = 0;

  // Table entries: write address, write data, read address, expected data
  localparam logic [23:0] VEC [8] = '{
    {4'd3,  8'h11, 4'd3,  8'h11},
    {4'd7,  8'h22, 4'd3,  8'h11},
    {4'd3,  8'h33, 4'd7,  8'h22},
    {4'd15, 8'hF0, 4'd3,  8'h33},
    {4'd0,  8'h0F, 4'd15, 8'hF0},
    {4'd9,  8'h5A, 4'd1,  8'h1E},
    {4'd9,  8'hA5, 4'd9,  8'hA5},
    {4'd12, 8'hC3, 4'd0,  8'h0F}
  };

  initial clk0 = 1'b0;
  always begin
    #(CLK_PERIOD/2);
    if (run0) clk0 = ~clk0;
  end

  initial begin
    clk1 = 1'b0;
    #0.5;
    forever begin
      #7;
      if (run1) clk1 = ~clk1;
    end
  end

  for (genvar m = 0; m < NMODE; m++) begin : g_mode
    dual_clock_ram #(.DATA_W(DW), .ADDR_W(AW), .MODE(clk_mode_e'(m))) u_dut (
      .clk_pri(clk0), .clk_sec(clk1), .ce_pri(ce_pri), .ce_sec(ce_sec),
      .rst_n(rst_n), .a_wdata(a_wdata), .a_addr(a_addr), .a_wen(a_wen),
      .b_addr(b_addr), .b_ren(b_ren), .b_addr_hold(b_hold), .b_rdata(q_all[m]));
  end

  task automatic tick0(input int n);
    repeat (n) @(posedge clk0);
    #1;
  endtask

  task automatic tick1(input int n);
    repeat (n) @(posedge clk1);
    #1;
  endtask

  task automatic settle();
    tick0(4);
    tick1(4);
  endtask

  task automatic chk(input string req, input int m, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s mode %0d: actual %h expected %h", req, m, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    a_addr = a; a_wdata = d; a_wen = 1'b1;
    tick0(1);
    a_wen = 1'b0;
    if (ce_pri) model_mem[a] = d;
  endtask

  task automatic read_all(input logic [AW-1:0] a, input string req);
    b_addr = a; b_ren = 1'b1;
    settle();
    for (int m = 0; m < NMODE; m++) chk(req, m, q_all[m], model_mem[a]);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] exp_m [NMODE];
    logic [DW-1:0] old_v;
    run0 = 1'b1; run1 = 1'b1; rst_n = 1'b0; ce_pri = 1'b1; ce_sec = 1'b1;
    a_wdata = '0; a_addr = '0; a_wen = 1'b0;
    b_addr = 4'd5; b_ren = 1'b0; b_hold = 1'b1;
    settle();
    rst_n = 1'b1;
    settle();
    // R7: read data is zero out of reset
    for (int m = 0; m < NMODE; m++) chk("R7 reset rdata", m, q_all[m], '0);
    // R7/R4: address register reset to 0 and held, so address 5 is ignored
    wr(4'd0, 8'hA5);
    b_ren = 1'b1;
    settle();
    for (int m = 0; m < NMODE; m++) chk("R7 reset address", m, q_all[m], 8'hA5);
    b_hold = 1'b0;

    for (int a = 0; a < (1<<AW); a++) wr(a[AW-1:0], {a[3:0], ~a[3:0]});

    // R1/R2 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][23:20], VEC[i][19:12]);
      b_addr = VEC[i][11:8]; b_ren = 1'b1;
      settle();
      for (int m = 0; m < NMODE; m++) chk("R1/R2 table", m, q_all[m], VEC[i][7:0]);
    end

    // R1/R5 random traffic with occasional write enable gating
    for (int i = 0; i < 60; i++) begin
      ce_pri = ($urandom_range(3) != 0);
      wr(4'($urandom_range(15)), 8'($urandom_range(255)));
      ce_pri = 1'b1;
      read_all(4'($urandom_range(15)), "R1/R2 random");
    end

    // R2: single-clock latency
    read_all(4'd2, "R2 setup");
    b_addr = 4'd6;
    tick0(1);
    chk("R2 latency capture edge", 0, q_all[0], model_mem[2]);
    tick0(1);
    chk("R2 latency data edge", 0, q_all[0], model_mem[6]);
    // R8: same-edge collision in single-clock mode
    old_v = model_mem[6];
    a_addr = 4'd6; a_wdata = ~old_v; a_wen = 1'b1;
    tick0(1);
    a_wen = 1'b0;
    model_mem[6] = ~old_v;
    chk("R8 collision old data", 0, q_all[0], old_v);
    tick0(1);
    chk("R8 new data next edge", 0, q_all[0], ~old_v);

    // R3: read enable low holds output
    settle();
    old_v = model_mem[6];
    b_ren = 1'b0; b_addr = 4'd11;
    wr(4'd6, 8'h3C);
    settle();
    for (int m = 0; m < NMODE; m++) chk("R3 ren low hold", m, q_all[m], old_v);

    // R4: hold freezes address, reads track contents
    read_all(4'd4, "R4 setup");
    b_hold = 1'b1; b_addr = 4'd13;
    wr(4'd4, 8'h77);
    settle();
    for (int m = 0; m < NMODE; m++) chk("R4 held address", m, q_all[m], 8'h77);
    b_hold = 1'b0;
    read_all(4'd13, "R4 release");

    // R5/R6: secondary enable low
    ce_sec = 1'b0; b_addr = 4'd10;
    settle();
    exp_m = '{model_mem[10], model_mem[13], model_mem[13], model_mem[13]};
    for (int m = 0; m < NMODE; m++) chk("R5 ce_sec low", m, q_all[m], exp_m[m]);
    ce_sec = 1'b1;
    read_all(4'd10, "R5 ce_sec restored");
    // R5/R6: primary enable low blocks write and primary registers
    ce_pri = 1'b0; b_addr = 4'd8;
    wr(4'd10, ~model_mem[10]);
    settle();
    exp_m = '{model_mem[10], model_mem[8], model_mem[10], model_mem[8]};
    for (int m = 0; m < NMODE; m++) chk("R5 ce_pri low", m, q_all[m], exp_m[m]);
    ce_pri = 1'b1;
    read_all(4'd10, "R1 gated write ignored");

    // R6: stop one clock at a time to expose the register placement
    read_all(4'd8, "R6 setup");
    run1 = 1'b0; b_addr = 4'd5;
    tick0(4);
    run0 = 1'b0; b_addr = 4'd14;
    run1 = 1'b1;
    tick1(4);
    exp_m = '{model_mem[5], model_mem[14], model_mem[5], model_mem[14]};
    for (int m = 0; m < NMODE; m++) chk("R6 clock placement", m, q_all[m], exp_m[m]);
    run0 = 1'b1;
    read_all(4'd14, "R6 both clocks");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule